// File: doc/BRIEF.md
# PLL Start Stabilization Sequencer

This block sequences the turn-on of a PLL. Software first stops a small stabilization timer, chooses a prescaler setting and loads a start count. It then writes 1 to the PLL enable bit. That single write switches the PLL on, halts the processor and starts the timer. The timer counts upward from the loaded value, one step per prescaled tick. When it wraps from 0xFF to 0x00, the processor clock enable returns, the timer's run bit clears and a one-cycle done pulse is issued. No separate write is needed to start or stop the timer.

While the wait lasts, a select output tells the clock-output path to carry the raw, still-settling PLL clock. A second PLL can be marked as already on. In that case the one loaded count must cover both PLLs settling, so the wait length still depends only on the preload and the prescaler. The block also keeps an output clock division ratio and a strobe at that ratio. Codes that are not allowed are refused, and a sticky error flag records them.

The control state machine has three states:
- IDLE: the clock is running and register writes are accepted.
- WAIT: the processor is halted and the timer is counting.
- RESUME: a single cycle in which the clock is back and done is high.

It has three transitions:
- start: from IDLE to WAIT, on an accepted enable write.
- overflow: from WAIT to RESUME, when the counter wraps.
- finish: from RESUME to IDLE, always, after one cycle.

Top module: `pll_start_seq`

## Requirements
- R1: After synchronous active-high reset, the outputs are as follows:
  - cpu_clk_en is 1, and cpu_halt, done_pulse, pll1_on, pll2_on, raw_clk_out_sel and tmr_running are 0.
  - tmr_count is 0x00.
  - div_denom is 2, and div_err is 0.
- R2: The block starts a wait on a write to address 0 with wr_data[0]=1, when the PLL is off and the timer run bit is 0. From the next cycle, for the whole wait:
  - cpu_clk_en is 0.
  - cpu_halt is 1.
  - raw_clk_out_sel is 1.
  - tmr_running is 1.
  - pll1_on is 1.
- R3: Take P as the count loaded at address 2 and S as the select in wr_data[3:1] at address 1. cpu_clk_en then stays 0 for exactly (256-P)*2^(S+1) cycles.
- R4: The wait ends on the cycle the counter passes 0xFF to 0x00. On that cycle:
  - cpu_clk_en returns to 1 and cpu_halt to 0.
  - done_pulse is 1 for that cycle only.
  - tmr_running is 0.
  - tmr_count is 0x00.
- R5: An enable write (address 0, wr_data[0]=1) is ignored while the timer run bit (address 1, wr_data[0]) is 1. The PLL stays off and the clock stays enabled.
- R6: During a wait, writes to addresses 0, 1 and 2 are ignored. pll1_on and pll2_on keep their values, and the wait length is unchanged.
- R7: wr_data[1] at address 0 sets pll2_on. The wait length does not depend on it.
- R8: The division code in wr_data[2:0] at address 3 gives div_denom as follows: 0→2, 1→3, 2→4, 3→6, 4→8.
- R9: A division code of 5, 6 or 7 is ignored, so div_denom keeps its value. It also sets div_err, which then stays 1 until reset.
- R10: div_strobe pulses once every div_denom cycles.
- R11: In IDLE, writing 0 to the enable bit turns pll1_on off. Writing 1 while pll1_on is already 1 starts no wait.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 2 | Register address (0 control, 1 timer setup, 2 count, 3 divider) |
| wr_data | input | 8 | Write data |
| cpu_clk_en | output | 1 | Processor clock enable |
| cpu_halt | output | 1 | Processor halt request |
| done_pulse | output | 1 | One-cycle pulse when the clock returns |
| pll1_on | output | 1 | Main PLL enable |
| pll2_on | output | 1 | Second PLL marked on |
| raw_clk_out_sel | output | 1 | Clock output carries the raw PLL clock |
| tmr_running | output | 1 | Timer run bit |
| tmr_count | output | 8 | Timer count value |
| div_denom | output | 4 | Current division denominator |
| div_err | output | 1 | Sticky prohibited-code flag |
| div_strobe | output | 1 | Pulse at the division rate |

## Verification
The wait is measured with three kinds of preload and prescaler pair:
- A single-tick wait (0xFF with select 0) shows the off-by-one edges of both the start and the overflow.
- Longer waits with different selects show that the prescaler scales the length, and that the preload value sets it.
- A wait flooded with enable, preload and prescaler writes shows whether mid-wait writes are really refused. A wait with the second PLL marked on must give the same length as one without it.

For the divider, every allowed code is followed by a measurement of the strobe period. This separates a correct decode from a shifted table. Each prohibited code is then followed by a check that the ratio is unchanged and the error flag stays set.

// File: rtl/pll_seq_pkg.sv
package pll_seq_pkg;

    typedef enum logic [1:0] {
        ST_IDLE   = 2'd0,
        ST_WAIT   = 2'd1,
        ST_RESUME = 2'd2
    } seq_state_t;

    localparam logic [1:0] ADDR_CTRL  = 2'd0;
    localparam logic [1:0] ADDR_TSET  = 2'd1;
    localparam logic [1:0] ADDR_COUNT = 2'd2;
    localparam logic [1:0] ADDR_DIV   = 2'd3;

    function automatic logic div_code_ok(input logic [2:0] code);
        return code <= 3'd4;
    endfunction

    function automatic logic [3:0] div_code_denom(input logic [2:0] code);
        logic [3:0] d;
        unique case (code)
            3'd0:    d = 4'd2;
            3'd1:    d = 4'd3;
            3'd2:    d = 4'd4;
            3'd3:    d = 4'd6;
            3'd4:    d = 4'd8;
            default: d = 4'd2;
        endcase
        return d;
    endfunction

endpackage

// File: rtl/pll_stab_timer.sv
module pll_stab_timer #(
    parameter int CNT_W = 8,
    parameter int SEL_W = 3
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             start,
    input  logic             cfg_we,
    input  logic             cfg_run,
    input  logic [SEL_W-1:0] cfg_sel,
    input  logic             load_we,
    input  logic [CNT_W-1:0] load_val,
    input  logic             stop_on_ovf,
    output logic [CNT_W-1:0] count,
    output logic             running,
    output logic             ovf
);
    localparam int PRESC_W = 2 ** SEL_W;

    logic [SEL_W-1:0]   sel_q;
    logic [PRESC_W-1:0] presc_q;
    logic [PRESC_W-1:0] mask;
    logic               tick;

    always_comb begin
        for (int i = 0; i < PRESC_W; i++) begin
            mask[i] = (i <= int'(sel_q));
        end
    end

    assign tick = running && ((presc_q & mask) == mask);
    assign ovf  = tick && (count == {CNT_W{1'b1}});

    always_ff @(posedge clk) begin
        if (rst) begin
            presc_q <= '0;
            sel_q   <= '0;
            running <= 1'b0;
        end else if (start) begin
            presc_q <= '0;
            running <= 1'b1;
        end else if (cfg_we) begin
            presc_q <= '0;
            sel_q   <= cfg_sel;
            running <= cfg_run;
        end else begin
            if (running) begin
                presc_q <= presc_q + 1'b1;
            end
            if (ovf && stop_on_ovf) begin
                running <= 1'b0;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            count <= '0;
        end else if (load_we) begin
            count <= load_val;
        end else if (tick) begin
            count <= count + 1'b1;
        end
    end
endmodule

// File: rtl/pll_div_ctrl.sv
module pll_div_ctrl
    import pll_seq_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic       code_we,
    input  logic [2:0] code_in,
    output logic [3:0] denom,
    output logic       err,
    output logic       strobe
);
    logic [2:0] code_q;
    logic [3:0] phase_q;
    logic       accept;

    assign accept = code_we && div_code_ok(code_in);
    assign denom  = div_code_denom(code_q);
    assign strobe = (phase_q == denom - 4'd1);

    always_ff @(posedge clk) begin
        if (rst) begin
            code_q <= 3'd0;
            err    <= 1'b0;
        end else if (code_we) begin
            if (accept) begin
                code_q <= code_in;
            end else begin
                err <= 1'b1;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst || accept || strobe) begin
            phase_q <= 4'd0;
        end else begin
            phase_q <= phase_q + 4'd1;
        end
    end
endmodule

// File: rtl/pll_seq_fsm.sv
module pll_seq_fsm
    import pll_seq_pkg::*;
(
    input  logic clk,
    input  logic rst,
    input  logic start_req,
    input  logic ovf,
    output logic in_wait,
    output logic clk_en,
    output logic halt,
    output logic done,
    output logic raw_sel
);
    seq_state_t state_q, state_d;

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:   if (start_req) state_d = ST_WAIT;
            ST_WAIT:   if (ovf)       state_d = ST_RESUME;
            ST_RESUME: state_d = ST_IDLE;
            default:   state_d = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= ST_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    always_comb begin
        in_wait = 1'b0;
        clk_en  = 1'b1;
        halt    = 1'b0;
        done    = 1'b0;
        raw_sel = 1'b0;
        unique case (state_q)
            ST_IDLE: ;
            ST_WAIT: begin
                in_wait = 1'b1;
                clk_en  = 1'b0;
                halt    = 1'b1;
                raw_sel = 1'b1;
            end
            ST_RESUME: done = 1'b1;
            default: ;
        endcase
    end
endmodule

// File: rtl/pll_start_seq.sv
module pll_start_seq
    import pll_seq_pkg::*;
#(
    parameter int CNT_W = 8,
    parameter int SEL_W = 3
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             wr_en,
    input  logic [1:0]       wr_addr,
    input  logic [7:0]       wr_data,
    output logic             cpu_clk_en,
    output logic             cpu_halt,
    output logic             done_pulse,
    output logic             pll1_on,
    output logic             pll2_on,
    output logic             raw_clk_out_sel,
    output logic             tmr_running,
    output logic [CNT_W-1:0] tmr_count,
    output logic [3:0]       div_denom,
    output logic             div_err,
    output logic             div_strobe
);
    logic in_wait;
    logic open_wr;
    logic wr_ctrl, wr_tset, wr_count, wr_div;
    logic start_req;
    logic tmr_ovf;

    assign open_wr  = wr_en && !in_wait;
    assign wr_ctrl  = open_wr && (wr_addr == ADDR_CTRL);
    assign wr_tset  = open_wr && (wr_addr == ADDR_TSET);
    assign wr_count = open_wr && (wr_addr == ADDR_COUNT);
    assign wr_div   = wr_en   && (wr_addr == ADDR_DIV);

    assign start_req = wr_ctrl && wr_data[0] && !pll1_on && !tmr_running;

    always_ff @(posedge clk) begin
        if (rst) begin
            pll1_on <= 1'b0;
            pll2_on <= 1'b0;
        end else if (wr_ctrl) begin
            pll2_on <= wr_data[1];
            if (!wr_data[0]) begin
                pll1_on <= 1'b0;
            end else if (start_req) begin
                pll1_on <= 1'b1;
            end
        end
    end

    pll_stab_timer #(.CNT_W(CNT_W), .SEL_W(SEL_W)) timer_i (
        .clk         (clk),
        .rst         (rst),
        .start       (start_req),
        .cfg_we      (wr_tset),
        .cfg_run     (wr_data[0]),
        .cfg_sel     (wr_data[SEL_W:1]),
        .load_we     (wr_count),
        .load_val    (wr_data[CNT_W-1:0]),
        .stop_on_ovf (in_wait),
        .count       (tmr_count),
        .running     (tmr_running),
        .ovf         (tmr_ovf)
    );

    pll_seq_fsm fsm_i (
        .clk       (clk),
        .rst       (rst),
        .start_req (start_req),
        .ovf       (tmr_ovf),
        .in_wait   (in_wait),
        .clk_en    (cpu_clk_en),
        .halt      (cpu_halt),
        .done      (done_pulse),
        .raw_sel   (raw_clk_out_sel)
    );

    pll_div_ctrl div_i (
        .clk     (clk),
        .rst     (rst),
        .code_we (wr_div),
        .code_in (wr_data[2:0]),
        .denom   (div_denom),
        .err     (div_err),
        .strobe  (div_strobe)
    );
endmodule

// File: rtl/pll_start_seq_chk.sv
module pll_start_seq_chk #(
    parameter int CNT_W = 8
) (
    input logic             clk,
    input logic             rst,
    input logic             cpu_clk_en,
    input logic             cpu_halt,
    input logic             done_pulse,
    input logic             pll1_on,
    input logic             pll2_on,
    input logic             raw_clk_out_sel,
    input logic             tmr_running,
    input logic [CNT_W-1:0] tmr_count,
    input logic [3:0]       div_denom,
    input logic             div_err
);
    assert_wait_entry_R2: assert property (@(posedge clk) disable iff (rst)
        $fell(cpu_clk_en) |-> (pll1_on && tmr_running));

    assert_wait_outputs_R2: assert property (@(posedge clk) disable iff (rst)
        !cpu_clk_en |-> (cpu_halt && raw_clk_out_sel));

    assert_count_up_R3: assert property (@(posedge clk) disable iff (rst)
        (!cpu_clk_en && $past(!cpu_clk_en)) |-> (tmr_count >= $past(tmr_count)));

    assert_resume_done_R4: assert property (@(posedge clk) disable iff (rst)
        $rose(cpu_clk_en) |-> (done_pulse && !tmr_running && tmr_count == '0));

    assert_done_single_R4: assert property (@(posedge clk) disable iff (rst)
        done_pulse |=> !done_pulse);

    assert_ctrl_frozen_R6: assert property (@(posedge clk) disable iff (rst)
        (!cpu_clk_en && $past(!cpu_clk_en)) |-> ($stable(pll1_on) && $stable(pll2_on)));

    assert_denom_legal_R8: assert property (@(posedge clk) disable iff (rst)
        (div_denom == 4'd2 || div_denom == 4'd3 || div_denom == 4'd4 ||
         div_denom == 4'd6 || div_denom == 4'd8));

    assert_err_sticky_R9: assert property (@(posedge clk) disable iff (rst)
        div_err |=> div_err);
endmodule

bind pll_start_seq pll_start_seq_chk #(.CNT_W(CNT_W)) chk_i (
    .clk             (clk),
    .rst             (rst),
    .cpu_clk_en      (cpu_clk_en),
    .cpu_halt        (cpu_halt),
    .done_pulse      (done_pulse),
    .pll1_on         (pll1_on),
    .pll2_on         (pll2_on),
    .raw_clk_out_sel (raw_clk_out_sel),
    .tmr_running     (tmr_running),
    .tmr_count       (tmr_count),
    .div_denom       (div_denom),
    .div_err         (div_err)
);

// File: tb/pll_start_seq_tb_top.sv
module pll_start_seq_tb_top;
    localparam int CLK_PERIOD = 10;
    localparam int WATCHDOG   = 150000;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       wr_en = 1'b0;
    logic [1:0] wr_addr = 2'd0;
    logic [7:0] wr_data = 8'd0;
    logic       cpu_clk_en, cpu_halt, done_pulse, pll1_on, pll2_on;
    logic       raw_clk_out_sel, tmr_running, div_err, div_strobe;
    logic [7:0] tmr_count;
    logic [3:0] div_denom;

    int checks = 0;
    int fails  = 0;
    int cyc    = 0;

    always #(CLK_PERIOD / 2) clk = ~clk;
    always @(posedge clk) cyc <= cyc + 1;

    pll_start_seq dut_i (
        .clk(clk), .rst(rst), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
        .cpu_clk_en(cpu_clk_en), .cpu_halt(cpu_halt), .done_pulse(done_pulse),
        .pll1_on(pll1_on), .pll2_on(pll2_on), .raw_clk_out_sel(raw_clk_out_sel),
        .tmr_running(tmr_running), .tmr_count(tmr_count), .div_denom(div_denom),
        .div_err(div_err), .div_strobe(div_strobe)
    );

    task automatic check(input string req, input string what, input int act, input int exp);
        checks++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    task automatic wr(input logic [1:0] a, input logic [7:0] d);
        @(negedge clk);
        wr_en = 1'b1; wr_addr = a; wr_data = d;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic wait_resume(input int c0, output int len);
        int guard = 0;
        while (cpu_clk_en == 1'b0 && guard < 70000) begin
            @(negedge clk);
            guard++;
        end
        len = cyc - c0;
    endtask

    task automatic t_reset();
        check("R1", "clk_en", int'(cpu_clk_en), 1);
        check("R1", "halt", int'(cpu_halt), 0);
        check("R1", "done", int'(done_pulse), 0);
        check("R1", "pll1", int'(pll1_on), 0);
        check("R1", "pll2", int'(pll2_on), 0);
        check("R1", "raw_sel", int'(raw_clk_out_sel), 0);
        check("R1", "running", int'(tmr_running), 0);
        check("R1", "count", int'(tmr_count), 0);
        check("R1", "denom", int'(div_denom), 2);
        check("R1", "err", int'(div_err), 0);
    endtask

    task automatic t_wait(input int p, input int s, input bit second);
        int c0, len;
        wr(2'd2, 8'(p));
        wr(2'd1, 8'(s << 1));
        wr(2'd0, {6'd0, second, 1'b1});
        c0 = cyc;
        check("R2", "clk_en low", int'(cpu_clk_en), 0);
        check("R2", "halt", int'(cpu_halt), 1);
        check("R2", "raw_sel", int'(raw_clk_out_sel), 1);
        check("R2", "running", int'(tmr_running), 1);
        check("R2", "pll1", int'(pll1_on), 1);
        check("R7", "pll2", int'(pll2_on), int'(second));
        wait_resume(c0, len);
        check(second ? "R7" : "R3", "wait length", len, (256 - p) * (1 << (s + 1)));
        check("R4", "done", int'(done_pulse), 1);
        check("R4", "halt", int'(cpu_halt), 0);
        check("R4", "running", int'(tmr_running), 0);
        check("R4", "count", int'(tmr_count), 0);
        @(negedge clk);
        check("R4", "done single", int'(done_pulse), 0);
        wr(2'd0, 8'd1);
        check("R11", "reenable no wait", int'(cpu_clk_en), 1);
        wr(2'd0, 8'd0);
        check("R11", "pll1 off", int'(pll1_on), 0);
    endtask

    task automatic t_ignore_in_wait();
        int c0, len;
        wr(2'd2, 8'hF0);
        wr(2'd1, 8'd2);
        wr(2'd0, 8'd1);
        c0 = cyc;
        wr(2'd0, 8'd2);
        wr(2'd2, 8'h00);
        wr(2'd1, 8'd14);
        check("R6", "pll1 kept", int'(pll1_on), 1);
        check("R6", "pll2 kept", int'(pll2_on), 0);
        wait_resume(c0, len);
        check("R6", "wait length", len, 16 * 4);
        wr(2'd0, 8'd0);
    endtask

    task automatic t_run_blocks();
        wr(2'd1, 8'd1);
        wr(2'd0, 8'd1);
        check("R5", "clk_en kept", int'(cpu_clk_en), 1);
        check("R5", "pll1 off", int'(pll1_on), 0);
        wr(2'd1, 8'd0);
    endtask

    task automatic t_div(input int code, input int exp);
        int guard, c0, per;
        wr(2'd3, 8'(code));
        check("R8", "denom", int'(div_denom), exp);
        guard = 0;
        while (div_strobe == 1'b0 && guard < 20) begin @(negedge clk); guard++; end
        c0 = cyc;
        @(negedge clk);
        guard = 0;
        while (div_strobe == 1'b0 && guard < 20) begin @(negedge clk); guard++; end
        per = cyc - c0;
        check("R10", "strobe period", per, exp);
    endtask

    task automatic t_bad_div();
        wr(2'd3, 8'd3);
        for (int c = 5; c < 8; c++) begin
            wr(2'd3, 8'(c));
            check("R9", "denom kept", int'(div_denom), 6);
            check("R9", "err set", int'(div_err), 1);
        end
        wr(2'd3, 8'd1);
        check("R9", "err sticky", int'(div_err), 1);
    endtask

    initial begin
        repeat (WATCHDOG) @(posedge clk);
        fails++;
        checks++;
        $display("FAIL watchdog: actual timeout expected finish");
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        t_reset();
        t_wait(8'hFF, 0, 1'b0);
        t_wait(8'hFC, 2, 1'b0);
        t_wait(8'hF0, 1, 1'b0);
        t_wait(8'hF8, 0, 1'b1);
        t_wait(8'hF8, 0, 1'b0);
        t_ignore_in_wait();
        t_run_blocks();
        t_div(0, 2);
        t_div(1, 3);
        t_div(2, 4);
        t_div(3, 6);
        t_div(4, 8);
        t_bad_div();
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end
endmodule